// File: doc/BRIEF.md
# Modem Status Change Detector

This block holds the modem status byte of one serial channel. Four active-low handshake lines arrive from the line side: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line is brought into the clock domain through two flops. The block then keeps one sticky change flag per line in the low nibble of the byte, and shows the active-high level of each line in the high nibble.

When the host reads the byte, the change flags clear. The interrupt output is high while any change flag is set and the enable input is high. A self-test mode takes the four levels from the channel's modem control outputs instead of the pins. The change flags then follow edges on those control bits. Address decode and the control register itself sit outside this block, and their results arrive as plain inputs.

Top module: `mdm_stat_unit`

## Requirements
- R1: After reset, with all four pins held high (inactive), `stat_q` reads 8'h00 and `irq` is 0.
- R2: `stat_q[0]` sets after any edge of the clear-to-send level and stays set until a read.
- R3: `stat_q[1]` sets after any edge of the data-set-ready level and stays set until a read.
- R4: `stat_q[2]` sets only when the `ri_n` pin goes from 0 to 1. A 1-to-0 change of `ri_n` leaves the bit unchanged.
- R5: `stat_q[3]` sets after any edge of the carrier-detect level and stays set until a read.
- R6: With `loop_en` low, `stat_q[7:4]` equals `~{dcd_n, ri_n, dsr_n, cts_n}` delayed by two clock edges. A pin change applied before edge k appears after edge k+1, and the change flag it causes appears after edge k+2.
- R7: With `loop_en` high, `stat_q[7:4]` equals `{ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts}` with no delay. The change flags follow the level shown in `stat_q[7:4]`, including a step caused by toggling `loop_en`.
- R8: A clock edge with `rd_stb` high clears `stat_q[3:0]` when no new change is seen at that edge.
- R9: If a change is detected at the same edge as `rd_stb`, the flag for that line is 1 after the edge.
- R10: `irq` is high exactly when `irq_en` is high and at least one of `stat_q[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Self-test mode: take levels from the control bits |
| ctl_rts | input | 1 | Request-to-send control bit |
| ctl_dtr | input | 1 | Data-terminal-ready control bit |
| ctl_aux1 | input | 1 | First auxiliary output control bit |
| ctl_aux2 | input | 1 | Second auxiliary output control bit |
| rd_stb | input | 1 | One-cycle strobe: host reads the status byte |
| irq_en | input | 1 | Modem status interrupt enable |
| stat_q | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem status interrupt request |

## Verification
The two functions that can fall in the same cycle are a host read, which clears the change flags, and a newly detected edge, which sets them. Random stimulus raises `rd_stb` on about a quarter of all cycles while pins and control bits toggle at random, so reads and detected edges often meet at the same clock edge. A directed case also times a pin change so that it reaches the edge detector exactly at a read. A bench model of the byte decides the outcome: the flag must survive under R9 and must clear under R8.

// File: rtl/mdm_stat_unit.sv
`timescale 1ns/1ps
module mdm_stat_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       ctl_rts,
  input  logic       ctl_dtr,
  input  logic       ctl_aux1,
  input  logic       ctl_aux2,
  input  logic       rd_stb,
  input  logic       irq_en,
  output logic [7:0] stat_q,
  output logic       irq
);

  logic [3:0] meta_q, sync_q, lvl_q, delta_q;
  logic [3:0] lvl, chg, evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= 4'hF;
      sync_q <= 4'hF;
    end else begin
      meta_q <= {dcd_n, ri_n, dsr_n, cts_n};
      sync_q <= meta_q;
    end

  assign lvl = loop_en ? {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts} : ~sync_q;
  assign chg = lvl ^ lvl_q;
  assign evt = {chg[3], lvl_q[2] & ~lvl[2], chg[1], chg[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= 4'h0;
      delta_q <= 4'h0;
    end else begin
      lvl_q   <= lvl;
      delta_q <= rd_stb ? evt : (delta_q | evt);
    end

  assign stat_q = {lvl, delta_q};
  assign irq    = irq_en & (|delta_q);

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && chg == 4'h0) |=> stat_q[3:0] == 4'h0);

  // R9
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && chg[0]) |=> stat_q[0]);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  // R4
  ri_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[2] && !(lvl_q[2] && !lvl[2])) |=> !stat_q[2]);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[3:0] != 4'h0));

endmodule

// File: tb/mdm_stat_unit_tb_top.sv
`timescale 1ns/1ps
module mdm_stat_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] pin_n = 4'hF, ctl = 4'h0;
  logic loop_en = 1'b0, rd_stb = 1'b0, irq_en = 1'b0;
  logic [7:0] stat_q;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_s1, m_s2, m_prev, m_delta;
  logic last_rd, last_evt;

  always #2 clk = ~clk;

  mdm_stat_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cts_n(pin_n[0]), .dsr_n(pin_n[1]), .ri_n(pin_n[2]), .dcd_n(pin_n[3]),
    .loop_en(loop_en), .ctl_rts(ctl[0]), .ctl_dtr(ctl[1]),
    .ctl_aux1(ctl[2]), .ctl_aux2(ctl[3]),
    .rd_stb(rd_stb), .irq_en(irq_en), .stat_q(stat_q), .irq(irq)
  );

  function automatic logic [3:0] exp_lvl();
    return loop_en ? ctl : ~m_s2;
  endfunction

  function automatic logic [3:0] exp_evt(input logic [3:0] lv);
    logic [3:0] c;
    c = lv ^ m_prev;
    return {c[3], m_prev[2] & ~lv[2], c[1], c[0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [3:0] lv;
    lv = exp_lvl();
    chk("R2 cts change flag", {7'd0, stat_q[0]}, {7'd0, m_delta[0]});
    chk("R3 dsr change flag", {7'd0, stat_q[1]}, {7'd0, m_delta[1]});
    chk("R4 ring trailing flag", {7'd0, stat_q[2]}, {7'd0, m_delta[2]});
    chk("R5 carrier change flag", {7'd0, stat_q[3]}, {7'd0, m_delta[3]});
    if (loop_en) chk("R7 loop levels", {4'd0, stat_q[7:4]}, {4'd0, lv});
    else         chk("R6 pin levels", {4'd0, stat_q[7:4]}, {4'd0, lv});
    chk("R10 irq", {7'd0, irq}, {7'd0, irq_en & (|m_delta)});
    if (last_rd && !last_evt) chk("R8 read clear", {4'd0, stat_q[3:0]}, {4'd0, m_delta});
    if (last_rd && last_evt)  chk("R9 read collision", {4'd0, stat_q[3:0]}, {4'd0, m_delta});
  endtask

  task automatic model_edge();
    logic [3:0] lv, ev;
    lv = exp_lvl();
    ev = exp_evt(lv);
    last_rd  = rd_stb;
    last_evt = |ev;
    m_delta  = rd_stb ? ev : (m_delta | ev);
    m_prev   = lv;
    m_s2     = m_s1;
    m_s1     = pin_n;
  endtask

  task automatic step(input logic [3:0] p, input logic [3:0] c, input logic lp,
                      input logic rd, input logic ie);
    @(negedge clk);
    compare();
    pin_n = p; ctl = c; loop_en = lp; rd_stb = rd; irq_en = ie;
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    int unsigned seed;
    logic [3:0] p, c;
    logic lp;
    seed = 32'h5a17;
    void'($urandom(seed));
    m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 4'h0; m_delta = 4'h0;
    last_rd = 1'b0; last_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset byte", stat_q, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    @(posedge clk);
    model_edge();

    // R4: ri_n falling must not set the flag, rising must
    step(4'hB, 4'h0, 1'b0, 1'b0, 1'b1);
    repeat (4) step(4'hB, 4'h0, 1'b0, 1'b0, 1'b1);
    step(4'hF, 4'h0, 1'b0, 1'b1, 1'b1);
    repeat (4) step(4'hF, 4'h0, 1'b0, 1'b0, 1'b1);
    // R9: cts edge reaches the detector at the same edge as a read
    step(4'hF, 4'h0, 1'b0, 1'b1, 1'b1);
    step(4'hE, 4'h0, 1'b0, 1'b0, 1'b1);
    step(4'hE, 4'h0, 1'b0, 1'b0, 1'b1);
    step(4'hE, 4'h0, 1'b0, 1'b1, 1'b1);
    repeat (3) step(4'hE, 4'h0, 1'b0, 1'b0, 1'b0);
    // R7: loopback levels and change flags from the control bits
    step(4'hE, 4'h0, 1'b1, 1'b1, 1'b1);
    step(4'hE, 4'h5, 1'b1, 1'b0, 1'b1);
    step(4'hE, 4'hA, 1'b1, 1'b1, 1'b1);
    step(4'hE, 4'hA, 1'b1, 1'b0, 1'b1);
    step(4'hE, 4'hA, 1'b0, 1'b1, 1'b1);
    repeat (3) step(4'hE, 4'hA, 1'b0, 1'b0, 1'b1);

    p = 4'hF; c = 4'h0; lp = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 4; b++)
        if ($urandom_range(0, 7) == 0) p[b] = ~p[b];
      if ($urandom_range(0, 5) == 0) c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 99) == 0) lp = ~lp;
      step(p, c, lp, $urandom_range(0, 3) == 0, $urandom_range(0, 7) != 0);
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule